// File: doc/BRIEF.md
# Cascadable Active-Low Priority Encoder

This block turns a bank of active-low request lines into the binary position of the most important request that is currently asserted. It is built from eight-line slices. Each slice reports an inverted three-bit position, a group-active flag and a pass-down enable. A slice that has no request of its own hands its enable to the next slice down the chain, so a request in a higher slice blocks every lower slice.

The top level holds a parameterised number of slices, two by default, which gives sixteen request lines. Slice s handles request bits `8s+7` down to `8s`, and the slice with the highest number has the highest priority. The wide index is formed in two parts. The upper bits are the inverted number of the slice that holds the winning request. The lower three bits are the AND of the per-slice index outputs, which works because every inactive slice drives all-ones. Every signal is active-low, and the block has no clock or storage.

Top module: `pe_cascade`

## Requirements
- R1: Within a slice, request line 7 has the highest priority and line 0 the lowest. When the slice is enabled and at least one request is low, the slice index equals the bitwise inverse of the winning line number: line 7 gives 3'b000 and line 0 alone gives 3'b111.
- R2: While a slice's enable input is high, its index, group and enable outputs are all high, whatever its requests are.
- R3: A slice's group output is low exactly when the slice is enabled and at least one of its request lines is low.
- R4: A slice's enable output is low exactly when the slice is enabled and all eight requests are high. In that case its index is 3'b111 and its group output is high.
- R5: Slices are chained. The top enable input drives the highest-numbered slice, and each slice's enable output drives the enable input of the slice one below it. A request in a higher slice therefore overrides every request in the lower slices.
- R6: When the top is enabled and any request is low, `idx_n` equals the bitwise inverse of the global bit number (0 to 8*NUM_SLICES-1) of the highest-numbered low request. Its upper bits are the inverted slice number and its low three bits are the inverted line within that slice.
- R7: The top `grp_n` is low exactly when the top is enabled and any request is low. The top `en_out_n` is the enable output of slice 0, so it is low exactly when the top is enabled and no request is low. When nothing is requested, `idx_n` is all ones.
- R8: While the top `en_n` is high, `idx_n`, `grp_n` and `en_out_n` are all high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| en_n | input | 1 | Active-low enable for the whole encoder |
| req_n | input | 8*NUM_SLICES | Active-low request lines; a higher bit has higher priority |
| idx_n | output | 3+SEL_W | Inverted binary position of the winning request (SEL_W = clog2 of NUM_SLICES, at least 1) |
| grp_n | output | 1 | Low when any request is active and the encoder is enabled |
| en_out_n | output | 1 | Low when the encoder is enabled and no request is active; used for further cascading |

## Verification
A standalone slice is driven through all 512 combinations of its enable and its eight requests. This separates the priority ordering from the disable override and the idle case. On the 16-line top, directed patterns assert each single line in turn, which shows that every slice number and line number is encoded correctly. Further patterns assert requests in both slices at once, so that a high slice must mask a low one, and assert requests while the encoder is disabled. Random multi-request vectors, with the enable mostly low, then mix all of these cases.

// File: rtl/pe_pkg.sv
// Package: shared widths for the priority encoder slices.
// Assumes a slice width of eight request lines with a three-bit index.
package pe_pkg;
    localparam int LANES = 8;
    localparam int IDX_W = $clog2(LANES);
endpackage

// File: rtl/pe_prio_find.sv
// Module: pe_prio_find
// Finds the highest-numbered set bit of an active-high vector.
// Assumes PW is wide enough to hold W-1. When no bit is set, pos is zero.
module pe_prio_find #(
    parameter int W  = 8,
    parameter int PW = 3
) (
    input  logic [W-1:0]  act,
    output logic          found,
    output logic [PW-1:0] pos
);
    // Purpose: scan upward so that the last active bit seen wins.
    always_comb begin
        found = 1'b0;
        pos   = '0;
        for (int i = 0; i < W; i++) begin
            if (act[i]) begin
                found = 1'b1;
                pos   = PW'(i);
            end
        end
    end

    // Purpose: the reported bit is set and no bit above it is set.
    always_comb begin
        // R1
        win_is_top_chk: assert (!found || ((act >> pos) == W'(1)))
            else $error("priority find picked a bit that is not the highest");
    end
endmodule

// File: rtl/pe_slice.sv
// Module: pe_slice
// Eight-line active-low priority encoder slice with an enable input and output.
// Assumes the enable input comes from the top or from the slice above it in the chain.
module pe_slice
    import pe_pkg::*;
(
    input  logic             en_n,
    input  logic [LANES-1:0] req_n,
    output logic [IDX_W-1:0] idx_n,
    output logic             grp_n,
    output logic             en_out_n
);
    logic             any_req;
    logic [IDX_W-1:0] win_pos;

    pe_prio_find #(.W(LANES), .PW(IDX_W)) u_find (
        .act   (~req_n),
        .found (any_req),
        .pos   (win_pos)
    );

    // Purpose: force every output high when disabled, otherwise encode the winning line.
    always_comb begin
        if (en_n) begin
            idx_n    = '1;
            grp_n    = 1'b1;
            en_out_n = 1'b1;
        end else begin
            idx_n    = any_req ? ~win_pos : '1;
            grp_n    = ~any_req;
            en_out_n = any_req;
        end
    end

    // Purpose: check the slice outputs against its inputs.
    always_comb begin
        // R2
        slice_off_high_chk: assert (!en_n || (idx_n == '1 && grp_n && en_out_n))
            else $error("disabled slice drives a low output");
        // R3
        slice_grp_chk: assert (en_n || (grp_n == (&req_n)))
            else $error("group output disagrees with requests");
        // R4
        slice_eo_chk: assert (en_n || (en_out_n == !(&req_n)))
            else $error("enable output disagrees with requests");
        // R1
        slice_idx_line_chk: assert (grp_n || !req_n[~idx_n])
            else $error("index points at an inactive line");
    end
endmodule

// File: rtl/pe_cascade.sv
// Module: pe_cascade
// Wide active-low priority encoder made of NUM_SLICES chained eight-line slices.
// Assumes slice s holds request bits 8s+7..8s and a higher slice wins.
module pe_cascade
    import pe_pkg::*;
#(
    parameter int NUM_SLICES = 2,
    localparam int SEL_W = (NUM_SLICES > 1) ? $clog2(NUM_SLICES) : 1,
    localparam int OUT_W = IDX_W + SEL_W,
    localparam int REQ_W = LANES * NUM_SLICES
) (
    input  logic             en_n,
    input  logic [REQ_W-1:0] req_n,
    output logic [OUT_W-1:0] idx_n,
    output logic             grp_n,
    output logic             en_out_n
);
    logic [NUM_SLICES-1:0] chain_in_n;
    logic [NUM_SLICES-1:0] chain_out_n;
    logic [NUM_SLICES-1:0] sl_grp_n;
    logic [IDX_W-1:0]      sl_idx_n [NUM_SLICES];
    logic                  sl_found;
    logic [SEL_W-1:0]      sl_pos;
    logic [IDX_W-1:0]      low_idx_n;

    // Top enable feeds the highest slice, each slice feeds the one below it.
    assign chain_in_n[NUM_SLICES-1] = en_n;

    for (genvar s = 0; s < NUM_SLICES; s++) begin : g_slice
        if (s < NUM_SLICES - 1) begin : g_link
            assign chain_in_n[s] = chain_out_n[s+1];
        end
        pe_slice u_slice (
            .en_n     (chain_in_n[s]),
            .req_n    (req_n[s*LANES +: LANES]),
            .idx_n    (sl_idx_n[s]),
            .grp_n    (sl_grp_n[s]),
            .en_out_n (chain_out_n[s])
        );
    end

    pe_prio_find #(.W(NUM_SLICES), .PW(SEL_W)) u_sel (
        .act   (~sl_grp_n),
        .found (sl_found),
        .pos   (sl_pos)
    );

    // Purpose: merge the slice indices; inactive slices contribute all ones.
    always_comb begin
        low_idx_n = '1;
        for (int s = 0; s < NUM_SLICES; s++) begin
            low_idx_n = low_idx_n & sl_idx_n[s];
        end
    end

    // Purpose: assemble the wide index and the overall flags.
    always_comb begin
        idx_n    = {(sl_found ? ~sl_pos : {SEL_W{1'b1}}), low_idx_n};
        grp_n    = &sl_grp_n;
        en_out_n = chain_out_n[0];
    end

    // Purpose: check the chain and the top outputs.
    always_comb begin
        // R5
        one_slice_active_chk: assert ($countones(~sl_grp_n) <= 1)
            else $error("more than one slice reports a request");
        // R8
        top_off_high_chk: assert (!en_n || (idx_n == '1 && grp_n && en_out_n))
            else $error("disabled encoder drives a low output");
        // R7
        top_flags_excl_chk: assert (en_n || (grp_n != en_out_n))
            else $error("group and enable outputs both high or both low");
        // R6
        top_idx_line_chk: assert (grp_n || !req_n[~idx_n])
            else $error("wide index points at an inactive line");
    end
endmodule

// File: tb/pe_cascade_tb.sv
module pe_cascade_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NS    = 2;
    localparam int REQ_W = 8 * NS;
    localparam int OUT_W = 4;

    typedef struct packed {
        logic [2:0]       s_idx;
        logic             s_grp;
        logic             s_eo;
        logic             s_en;
        logic [OUT_W-1:0] t_idx;
        logic             t_grp;
        logic             t_eo;
        logic             t_en;
        logic [REQ_W-1:0] t_req;
    } item_t;

    logic clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic             s_en_n, t_en_n;
    logic [7:0]       s_req_n;
    logic [REQ_W-1:0] t_req_n;
    logic [2:0]       s_idx_n;
    logic             s_grp_n, s_eo_n;
    logic [OUT_W-1:0] t_idx_n;
    logic             t_grp_n, t_eo_n;

    int checks = 0;
    int fails  = 0;
    item_t sb_q[$];

    pe_slice u_slice (
        .en_n(s_en_n), .req_n(s_req_n), .idx_n(s_idx_n),
        .grp_n(s_grp_n), .en_out_n(s_eo_n)
    );

    pe_cascade #(.NUM_SLICES(NS)) u_dut (
        .en_n(t_en_n), .req_n(t_req_n), .idx_n(t_idx_n),
        .grp_n(t_grp_n), .en_out_n(t_eo_n)
    );

    // Reference: a W-bit active-low encoder with enable, written from the requirements.
    function automatic logic [5:0] ref_enc(input logic en, input logic [REQ_W-1:0] r, input int w);
        logic [3:0] p;
        logic       f;
        p = '0;
        f = 1'b0;
        for (int i = 0; i < w; i++) if (!r[i]) begin f = 1'b1; p = 4'(i); end
        if (en) return 6'b111111;
        if (!f) return {4'b1111, 1'b1, 1'b0};
        return {~p, 1'b0, 1'b1};
    endfunction

    task automatic drive(input logic se, input logic [7:0] sr, input logic te, input logic [REQ_W-1:0] tr);
        item_t it;
        logic [5:0] e;
        @(posedge clk);
        s_en_n = se; s_req_n = sr; t_en_n = te; t_req_n = tr;
        e = ref_enc(se, {8'hFF, sr}, 8);
        it.s_idx = e[4:2]; it.s_grp = e[1]; it.s_eo = e[0]; it.s_en = se;
        e = ref_enc(te, tr, REQ_W);
        it.t_idx = e[5:2]; it.t_grp = e[1]; it.t_eo = e[0]; it.t_en = te;
        it.t_req = tr;
        sb_q.push_back(it);
    endtask

    task automatic cmp(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: pop expected items and compare away from the driving edge.
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            item_t it;
            string ti;
            it = sb_q.pop_front();
            cmp(it.s_en ? "R2 slice idx" : "R1 slice idx", 8'(s_idx_n), 8'(it.s_idx));
            cmp(it.s_en ? "R2 slice grp" : "R3 slice grp", 8'(s_grp_n), 8'(it.s_grp));
            cmp(it.s_en ? "R2 slice eo"  : "R4 slice eo",  8'(s_eo_n),  8'(it.s_eo));
            if (it.t_en) ti = "R8 top idx";
            else if (!(&it.t_req[15:8]) && !(&it.t_req[7:0])) ti = "R5 top idx";
            else ti = "R6 top idx";
            cmp(ti, 8'(t_idx_n), 8'(it.t_idx));
            cmp(it.t_en ? "R8 top grp" : "R7 top grp", 8'(t_grp_n), 8'(it.t_grp));
            cmp(it.t_en ? "R8 top eo"  : "R7 top eo",  8'(t_eo_n),  8'(it.t_eo));
        end
    end

    logic done = 1'b0;

    initial begin
        s_en_n = 1'b1; s_req_n = '1; t_en_n = 1'b1; t_req_n = '1;
        // Reset-like state: disabled, no requests (R2, R8).
        drive(1'b1, 8'hFF, 1'b1, 16'hFFFF);
        // Exhaustive slice sweep (R1..R4); the top sees a related pattern.
        for (int v = 0; v < 512; v++) begin
            drive(v[8], v[7:0], v[8], {v[7:0], ~v[7:0]});
        end
        // Single request on each top line (R6), both enable states (R8).
        for (int b = 0; b < REQ_W; b++) begin
            drive(1'b0, 8'hFF, 1'b0, ~(16'(1) << b));
            drive(1'b0, 8'hFF, 1'b1, ~(16'(1) << b));
        end
        // Requests in both slices: the high slice must win (R5).
        drive(1'b0, 8'h7F, 1'b0, 16'hFEFE);
        drive(1'b0, 8'hFE, 1'b0, 16'h7F00);
        drive(1'b0, 8'h00, 1'b0, 16'h0000);
        // Idle but enabled: en_out_n low, index all ones (R7, R4).
        drive(1'b0, 8'hFF, 1'b0, 16'hFFFF);
        // Random multi-request vectors.
        for (int k = 0; k < 400; k++) begin
            drive(($urandom_range(0, 7) == 0), 8'($urandom), ($urandom_range(0, 7) == 0), 16'($urandom));
        end
        @(posedge clk);
        @(posedge clk);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                fails++;
                checks++;
                $display("FAIL watchdog actual=running expected=finished");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule